// File: doc/BRIEF.md
# Radix-4 Non-Redundant Signed-Digit Coefficient Encoder

This block rewrites a two's-complement coefficient of WIDTH bits (WIDTH even, K = WIDTH/2 radix-4 digits) into a compact signed-digit form. A multiplier can later read this form without running its own recoding. The K-1 lower digits each come from a ripple of half adders and are stored in two bits. Half of these adders are ordinary. The other half have their sum bit weighted negatively. The top digit is stored as a three-bit sign/two/one code in modified-Booth style. The packed result is WIDTH+1 bits wide.

The parameter ALT_FORM picks the digit set. With ALT_FORM = 0 each lower digit lies in {-2,-1,0,+1}. With ALT_FORM = 1 each lower digit lies in {-1,0,+1,+2}, and the ordinary and sign-modified adders swap places within the digit. One coefficient may be offered every cycle. A small controller with two states registers the result and its valid flag. In state ST_EMPTY no result is held. The transition EMPTY->FULL is taken on an accepted input. In state ST_FULL a result is held. The transition FULL->FULL is taken when another input arrives in the same cycle. The transition FULL->EMPTY is taken when no input arrives.

Top module: `sd4_coef_encoder`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_code is all zeros.
- R2: out_valid is 1 in the cycle after a cycle with in_valid high, and 0 in the cycle after a cycle with in_valid low.
- R3: With ALT_FORM = 0, for each digit j < K-1, bit 2j+1 carries weight -2·4^j and bit 2j carries weight +1·4^j. The decoded sum of all digits equals the accepted coefficient for every input value, including -2^(WIDTH-1).
- R4: With ALT_FORM = 1, for each digit j < K-1, bit 2j+1 carries weight +2·4^j and bit 2j carries weight -1·4^j. The decoded sum equals the accepted coefficient for every input value.
- R5: The top digit occupies bits [WIDTH:WIDTH-2] as {sign, two, one}, with value ±(2·two + one)·4^(K-1). The two and one bits are never both set, and sign is never set with a zero magnitude.
- R6: For WIDTH = 8 and ALT_FORM = 0, the codes are as follows: 0 gives 9'h000, 1 gives 9'h001, 3 gives 9'h007, -1 gives 9'h003, 127 gives 9'h083, and -128 gives 9'h180.
- R7: A cycle with in_valid low leaves out_code unchanged, whatever in_coef holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coefficient on in_coef is to be encoded |
| in_coef | input | WIDTH | Two's-complement coefficient |
| out_valid | output | 1 | out_code holds a fresh result |
| out_code | output | WIDTH+1 | Packed signed-digit code |

## Verification
The hardest case to reach is a carry that ripples through every digit into the top digit and cancels against the sign bit. An example is -1, whose lower digits are all zero except the first, and whose top code must come out as a non-negative zero. Another case is the most negative coefficient, which drives the top digit to -2 with no carry at all. The stimulus reaches both by sweeping every 8-bit coefficient through two instances, one per digit set. It also includes directed table entries for these values and for the largest positive value.

// File: rtl/sd4_pkg.sv
package sd4_pkg;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } sd4_state_e;

    // top digit code layout {sign, two, one}
    typedef struct packed {
        logic sign;
        logic two;
        logic one;
    } sd4_top_t;

endpackage

// File: rtl/sd4_digit_slice.sv
module sd4_digit_slice #(
    parameter bit ALT_FORM = 1'b0
) (
    input  logic       b_lo,
    input  logic       b_hi,
    input  logic       c_in,
    output logic [1:0] dig,
    output logic       c_out
);
    logic c_mid;
    logic s_lo;
    logic s_hi;

    generate
        if (ALT_FORM == 1'b0) begin : g_minus
            // ordinary half adder at the low bit, sign-modified at the high bit
            always_comb begin
                s_lo  = b_lo ^ c_in;
                c_mid = b_lo & c_in;
                s_hi  = b_hi ^ c_mid;
                c_out = b_hi | c_mid;
            end
        end else begin : g_plus
            // sign-modified half adder at the low bit, ordinary at the high bit
            always_comb begin
                s_lo  = b_lo ^ c_in;
                c_mid = b_lo | c_in;
                s_hi  = b_hi ^ c_mid;
                c_out = b_hi & c_mid;
            end
        end
    endgenerate

    assign dig = {s_hi, s_lo};
endmodule

// File: rtl/sd4_top_digit.sv
module sd4_top_digit
    import sd4_pkg::*;
(
    input  logic     b_msb,
    input  logic     b_nxt,
    input  logic     c_in,
    output sd4_top_t code
);
    // value = -2*b_msb + b_nxt + c_in
    always_comb begin
        code = '0;
        unique case ({b_msb, b_nxt, c_in})
            3'b000: code = '{sign: 1'b0, two: 1'b0, one: 1'b0};
            3'b001: code = '{sign: 1'b0, two: 1'b0, one: 1'b1};
            3'b010: code = '{sign: 1'b0, two: 1'b0, one: 1'b1};
            3'b011: code = '{sign: 1'b0, two: 1'b1, one: 1'b0};
            3'b100: code = '{sign: 1'b1, two: 1'b1, one: 1'b0};
            3'b101: code = '{sign: 1'b1, two: 1'b0, one: 1'b1};
            3'b110: code = '{sign: 1'b1, two: 1'b0, one: 1'b1};
            3'b111: code = '{sign: 1'b0, two: 1'b0, one: 1'b0};
            default: code = '0;
        endcase
    end
endmodule

// File: rtl/sd4_coef_encoder.sv
module sd4_coef_encoder
    import sd4_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter bit ALT_FORM = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_coef,
    output logic             out_valid,
    output logic [WIDTH:0]   out_code
);
    localparam int K      = WIDTH / 2;
    localparam int LOW_N  = K - 1;
    localparam int LOW_W  = 2 * LOW_N;

    initial begin
        if (WIDTH < 4 || (WIDTH % 2) != 0)
            $error("sd4_coef_encoder: WIDTH must be even and at least 4");
    end

    logic [K-1:0]     carry;
    logic [LOW_W-1:0] low_code;
    sd4_top_t         top_code;
    logic [WIDTH:0]   next_code;
    sd4_state_e       state_q;
    sd4_state_e       state_d;

    assign carry[0] = 1'b0;

    genvar j;
    generate
        for (j = 0; j < LOW_N; j++) begin : g_dig
            sd4_digit_slice #(.ALT_FORM(ALT_FORM)) u_slice (
                .b_lo  (in_coef[2*j]),
                .b_hi  (in_coef[2*j+1]),
                .c_in  (carry[j]),
                .dig   (low_code[2*j+1:2*j]),
                .c_out (carry[j+1])
            );
        end
    endgenerate

    sd4_top_digit u_top (
        .b_msb (in_coef[WIDTH-1]),
        .b_nxt (in_coef[WIDTH-2]),
        .c_in  (carry[K-1]),
        .code  (top_code)
    );

    assign next_code = {top_code, low_code};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_code <= '0;
        else if (in_valid) out_code <= next_code;
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: out_valid = 1'b0;
            ST_FULL:  out_valid = 1'b1;
            default:  out_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/sd4_coef_encoder_chk.sv
module sd4_coef_encoder_chk #(
    parameter int WIDTH    = 8,
    parameter bit ALT_FORM = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_coef,
    input logic             out_valid,
    input logic [WIDTH:0]   out_code
);
    localparam int K = WIDTH / 2;

    function automatic longint decode(input logic [WIDTH:0] c);
        longint acc;
        longint m;
        acc = 0;
        for (int j = 0; j < K - 1; j++) begin
            if (ALT_FORM) acc += (2 * longint'(c[2*j+1]) - longint'(c[2*j])) <<< (2*j);
            else          acc += (longint'(c[2*j]) - 2 * longint'(c[2*j+1])) <<< (2*j);
        end
        m = 2 * longint'(c[WIDTH-1]) + longint'(c[WIDTH-2]);
        if (c[WIDTH]) m = -m;
        acc += m <<< (2*(K-1));
        return acc;
    endfunction

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_code));

    // covers R3 or R4 depending on ALT_FORM
    assert_value_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (decode(out_code) == longint'($signed($past(in_coef)))));

    assert_top_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!(out_code[WIDTH-1] && out_code[WIDTH-2]) &&
                       (!out_code[WIDTH] || out_code[WIDTH-1] || out_code[WIDTH-2])));
endmodule

bind sd4_coef_encoder sd4_coef_encoder_chk #(.WIDTH(WIDTH), .ALT_FORM(ALT_FORM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_coef   (in_coef),
    .out_valid (out_valid),
    .out_code  (out_code)
);

// File: tb/sd4_coef_encoder_test.sv
`timescale 1ns/1ps
module sd4_coef_encoder_test;
    localparam int W = 8;
    localparam int K = W / 2;
    localparam int NVEC = 6;
    // {coefficient, expected code} for ALT_FORM = 0 (R6)
    localparam logic [W+W:0] VEC [NVEC] = '{
        {8'h00, 9'h000},
        {8'h01, 9'h001},
        {8'h03, 9'h007},
        {8'hFF, 9'h003},
        {8'h7F, 9'h083},
        {8'h80, 9'h180}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_coef = '0;
    logic         ov_m, ov_p;
    logic [W:0]   oc_m, oc_p;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sd4_coef_encoder #(.WIDTH(W), .ALT_FORM(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
        .out_valid(ov_m), .out_code(oc_m));

    sd4_coef_encoder #(.WIDTH(W), .ALT_FORM(1'b1)) uut_alt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
        .out_valid(ov_p), .out_code(oc_p));

    function automatic int value_of(input logic [W:0] c, input bit alt);
        int acc;
        int m;
        acc = 0;
        for (int j = 0; j < K - 1; j++) begin
            if (alt) acc += (2 * int'(c[2*j+1]) - int'(c[2*j])) * (1 << (2*j));
            else     acc += (int'(c[2*j]) - 2 * int'(c[2*j+1])) * (1 << (2*j));
        end
        m = 2 * int'(c[W-1]) + int'(c[W-2]);
        if (c[W]) m = -m;
        return acc + m * (1 << (2*(K-1)));
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [W-1:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_coef  = c;
        @(negedge clk);
    endtask

    initial begin
        int wd;
        wd = 0;
        while (!done) begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [W:0] held;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ov_m == 1'b0 && ov_p == 1'b0, "R1 valid", ov_m, 0);
        check(oc_m == '0 && oc_p == '0, "R1 code", oc_m, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ov_m == 1'b0, "R2 idle valid", ov_m, 0);

        // R6 table
        for (int i = 0; i < NVEC; i++) begin
            push(VEC[i][W+W:W+1]);
            check(ov_m == 1'b1, "R2 valid", ov_m, 1);
            check(oc_m == VEC[i][W:0], "R6 code", oc_m, VEC[i][W:0]);
        end

        // R3/R4/R5 exhaustive sweep
        for (int v = 0; v < (1 << W); v++) begin
            push(W'(v));
            check(value_of(oc_m, 1'b0) == int'($signed(W'(v))), "R3 value",
                  value_of(oc_m, 1'b0), $signed(W'(v)));
            check(value_of(oc_p, 1'b1) == int'($signed(W'(v))), "R4 value",
                  value_of(oc_p, 1'b1), $signed(W'(v)));
            check(!(oc_m[W-1] && oc_m[W-2]) && !(oc_m[W] && !oc_m[W-1] && !oc_m[W-2]),
                  "R5 top code", oc_m[W:W-2], 0);
            check(!(oc_p[W-1] && oc_p[W-2]) && !(oc_p[W] && !oc_p[W-1] && !oc_p[W-2]),
                  "R5 top code alt", oc_p[W:W-2], 0);
        end

        // R7: idle cycle with changed coefficient keeps the code
        push(8'h80);
        held = oc_m;
        in_valid = 1'b0;
        in_coef  = 8'h55;
        @(negedge clk);
        check(ov_m == 1'b0, "R2 fall", ov_m, 0);
        check(oc_m == held, "R7 hold", oc_m, held);
        @(negedge clk);
        check(oc_m == 9'h180, "R7 hold second", oc_m, 9'h180);

        // back-to-back: valid stays high (R2)
        push(8'h01);
        push(8'h03);
        check(ov_m == 1'b1 && oc_m == 9'h007, "R2 back-to-back", oc_m, 9'h007);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule